// File: doc/BRIEF.md
# Boot-Configurable Cascaded Clock Divider

This block turns one input clock into two clock-enable pulse trains. The first is a core/system enable set by a core divider field. The second is a bus/flash enable, produced by a bus divider that counts core enables, so the two ratios multiply. The enables are one input-clock cycle wide and are meant to qualify registers that run on the input clock. No gated clock is produced.

A two-bit boot option is captured while reset is held, and it picks the reset ratio of the core divider. The all-ones value selects the fastest ratio, because unprogrammed option storage reads as ones. Any zero bit selects a slower, lower-power ratio. The bus divider always comes out of reset at divide-by-2. After reset, software can rewrite both fields through a write port and read them back on a readback bus. While the low-power-run input is high, writes are refused, so the ratios must be set before entering that mode. A new ratio starts only after the current division period has finished.

Top module: `clkdiv_boot`

## Requirements
- R1: A divider field value F divides by F+1. The core field is `rd_data[3:0]` and the bus field is `rd_data[6:4]`. `rd_data` always shows the programmed fields.
- R2: The core field resets to 7, 3, 1 or 0 when `boot_opt` is 00, 01, 10 or 11 respectively.
- R3: The bus field resets to 1 (divide-by-2) for every `boot_opt` value.
- R4: Every reset restores both fields from `boot_opt`, replacing any earlier write.
- R5: `boot_opt` is captured only while `rst_n` is low. Changing it after reset changes neither `rd_data` nor the pulse rates.
- R6: When `wr_en` is high and `lp_run` is low at a clock edge, `rd_data` equals `wr_data` from the next cycle.
- R7: When `lp_run` is high, `wr_en` has no effect on `rd_data` or on the pulse periods.
- R8: With core field F, `core_ce` is a one-cycle pulse every F+1 cycles. After reset is released, the first pulse comes in cycle F, counting the first cycle with `rst_n` high as cycle 0.
- R9: `bus_ce` is high only together with `core_ce`, on every (B+1)-th core pulse, where B is the bus field. This gives a period of (F+1)(B+1). For example, F=0 and B=4 give divide-by-5.
- R10: A new field value takes effect only after the current period ends. The period in progress during a write keeps its old length.
- R11: `core_ce` and `bus_ce` are low while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset; boot option captured while low |
| boot_opt | input | 2 | Boot ratio option |
| lp_run | input | 1 | Low-power-run mode; blocks writes while high |
| wr_en | input | 1 | Divider register write strobe |
| wr_data | input | 7 | Write value, fields as in R1 |
| rd_data | output | 7 | Programmed divider fields |
| core_ce | output | 1 | Core/system clock-enable pulse |
| bus_ce | output | 1 | Bus/flash clock-enable pulse |

## Verification
Each divider keeps a count and an active ratio. If either holds a wrong value, a pulse arrives too early or too late, and the gap between consecutive pulses of that output shows the error within one period. A wrong programmed field shows on `rd_data` in the cycle after the write or the reset. A wrong active ratio shows as a period change no later than the next terminal count. The bench compares pulse-to-pulse intervals against queued expectations. After reset it also checks the absolute position of the first pulses, so that a phase error is caught as well.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   // Boot option encodings, slowest to fastest.
   typedef enum logic [1:0] {
      BOOT_SLOW8 = 2'b00,
      BOOT_SLOW4 = 2'b01,
      BOOT_SLOW2 = 2'b10,
      BOOT_FAST  = 2'b11
   } boot_sel_e;

   // Core field reset value: all-ones option gives divide-by-1.
   // Each step down in the option value doubles the ratio.
   function automatic int unsigned boot_core_field(input int unsigned sel,
                                                   input int unsigned sel_w);
      int unsigned top_sel;
      top_sel = (1 << sel_w) - 1;
      return (1 << (top_sel - sel)) - 1;
   endfunction

endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg #(
   parameter int CORE_W   = 4,
   parameter int BUS_W    = 3,
   parameter int BOOT_W   = 2,
   parameter int BUS_RST  = 1,
   parameter int CORE_LSB = 0,
   parameter int BUS_LSB  = 4,
   parameter int REG_W    = 7,
   parameter bit LOCK_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BOOT_W-1:0] boot_opt,
   input  logic              lp_run,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [CORE_W-1:0] core_div,
   output logic [BUS_W-1:0]  bus_div,
   output logic [CORE_W-1:0] boot_core,
   output logic [BUS_W-1:0]  boot_bus
);

   logic wr_ok;

   generate
      if (LOCK_EN) begin : g_lock
         assign wr_ok = wr_en & ~lp_run;
      end else begin : g_nolock
         logic unused_lp;
         assign unused_lp = lp_run;
         assign wr_ok = wr_en;
      end
   endgenerate

   always_comb begin
      boot_core = CORE_W'(clkdiv_pkg::boot_core_field(int'(boot_opt), BOOT_W));
      boot_bus  = BUS_W'(BUS_RST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         core_div <= boot_core;
         bus_div  <= boot_bus;
      end else if (wr_ok) begin
         core_div <= wr_data[CORE_LSB +: CORE_W];
         bus_div  <= wr_data[BUS_LSB +: BUS_W];
      end
   end

   // R6: an accepted write lands in both fields on the next cycle
   assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !lp_run) |=> (core_div == $past(wr_data[CORE_LSB +: CORE_W]) &&
                              bus_div  == $past(wr_data[BUS_LSB +: BUS_W])));

   // R7: fields frozen while low-power run holds
   assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_run && LOCK_EN) |=> ($stable(core_div) && $stable(bus_div)));

endmodule

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic [W-1:0] div_next,
   input  logic [W-1:0] div_boot,
   output logic         tick_o
);

   logic [W-1:0] cnt;
   logic [W-1:0] act;
   logic         term;

   assign term   = (cnt == act);
   assign tick_o = rst_n & adv & term;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         act <= div_boot;
      end else if (adv) begin
         if (term) begin
            cnt <= '0;
            act <= div_next;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R8: counter never passes the active terminal value
   assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= act);

   // R8: a pulse is followed by a gap unless the new ratio is divide-by-1
   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (!tick_o || act == '0));

   // R10: the active ratio changes only at a period boundary
   assert_ratio_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !term) |=> $stable(act));

endmodule

// File: rtl/clkdiv_boot.sv
module clkdiv_boot #(
   parameter int CORE_W  = 4,
   parameter int BUS_W   = 3,
   parameter int BOOT_W  = 2,
   parameter int BUS_RST = 1,
   parameter bit LOCK_EN = 1'b1,
   localparam int CORE_LSB = 0,
   localparam int BUS_LSB  = CORE_W,
   localparam int REG_W    = CORE_W + BUS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BOOT_W-1:0] boot_opt,
   input  logic              lp_run,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   output logic              core_ce,
   output logic              bus_ce
);

   localparam int SLOWEST = (1 << ((1 << BOOT_W) - 1)) - 1;

   generate
      if ((SLOWEST >> CORE_W) != 0) begin : g_bad_core_w
         $error("core field too narrow for slowest boot ratio");
      end
      if ((BUS_RST >> BUS_W) != 0) begin : g_bad_bus_rst
         $error("bus reset value does not fit bus field");
      end
   endgenerate

   logic [CORE_W-1:0] core_div, boot_core;
   logic [BUS_W-1:0]  bus_div, boot_bus;
   logic              core_tick;

   clkdiv_cfg #(
      .CORE_W(CORE_W), .BUS_W(BUS_W), .BOOT_W(BOOT_W), .BUS_RST(BUS_RST),
      .CORE_LSB(CORE_LSB), .BUS_LSB(BUS_LSB), .REG_W(REG_W), .LOCK_EN(LOCK_EN)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .boot_opt(boot_opt), .lp_run(lp_run),
      .wr_en(wr_en), .wr_data(wr_data), .core_div(core_div), .bus_div(bus_div),
      .boot_core(boot_core), .boot_bus(boot_bus)
   );

   clkdiv_stage #(.W(CORE_W)) u_core (
      .clk(clk), .rst_n(rst_n), .adv(1'b1), .div_next(core_div),
      .div_boot(boot_core), .tick_o(core_tick)
   );

   clkdiv_stage #(.W(BUS_W)) u_bus (
      .clk(clk), .rst_n(rst_n), .adv(core_tick), .div_next(bus_div),
      .div_boot(boot_bus), .tick_o(bus_ce)
   );

   assign core_ce = core_tick;

   always_comb begin
      rd_data = '0;
      rd_data[CORE_LSB +: CORE_W] = core_div;
      rd_data[BUS_LSB +: BUS_W]   = bus_div;
   end

   // R9: bus enable only ever coincides with a core enable
   assert_cascade_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ce |-> core_ce);

endmodule

// File: tb/clkdiv_boot_bench.sv
`timescale 1ns/1ps
module clkdiv_boot_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] boot_opt = 2'b11;
   logic       lp_run = 1'b0;
   logic       wr_en = 1'b0;
   logic [6:0] wr_data = '0;
   logic [6:0] rd_data;
   logic       core_ce, bus_ce;

   int total = 0;
   int bad = 0;
   int slot = 0;

   int  core_q[$];
   int  bus_q[$];
   int  core_prev = -1;
   int  bus_prev = -1;
   bit  core_on = 0;
   bit  bus_on = 0;

   always #2.5 clk = ~clk;

   clkdiv_boot u_clkdiv_boot (
      .clk(clk), .rst_n(rst_n), .boot_opt(boot_opt), .lp_run(lp_run),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .core_ce(core_ce), .bus_ce(bus_ce)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: pops an expected interval at each pulse while armed
   always @(negedge clk) begin
      if (core_on && core_ce) begin
         if (core_prev >= 0 && core_q.size() > 0) begin
            int iv;
            iv = core_q.pop_front();
            check((slot - core_prev) == iv, "R8/R10 core period", slot - core_prev, iv);
         end
         core_prev = slot;
         if (core_q.size() == 0) core_on = 0;
      end
      if (bus_on && bus_ce) begin
         if (bus_prev >= 0 && bus_q.size() > 0) begin
            int iv;
            iv = bus_q.pop_front();
            check((slot - bus_prev) == iv, "R9 bus period", slot - bus_prev, iv);
         end
         bus_prev = slot;
         if (bus_q.size() == 0) bus_on = 0;
      end
      slot++;
   end

   task automatic push_core(input int iv, input int n);
      for (int i = 0; i < n; i++) core_q.push_back(iv);
   endtask

   task automatic push_bus(input int iv, input int n);
      for (int i = 0; i < n; i++) bus_q.push_back(iv);
   endtask

   task automatic wait_idle();
      int n;
      n = 0;
      while ((core_on || bus_on) && n < 2000) begin
         @(posedge clk);
         n++;
      end
      check(!core_on && !bus_on, "scoreboard drained", core_q.size() + bus_q.size(), 0);
      core_q.delete(); bus_q.delete();
      core_on = 0; bus_on = 0;
   endtask

   // Reset with an option, then check readback and the absolute first pulses
   task automatic boot(input logic [1:0] opt, input int core_n, input int bus_m,
                       input logic [6:0] exp_rd);
      @(posedge clk); #1;
      rst_n = 1'b0;
      boot_opt = opt;
      for (int i = 0; i < 3; i++) begin
         @(posedge clk); #1;
         check(!core_ce && !bus_ce, "R11 quiet in reset", {core_ce, bus_ce}, 0);
      end
      check(rd_data == exp_rd, "R2/R3/R4 reset fields", rd_data, exp_rd);
      push_core(core_n, 3);
      push_bus(core_n * bus_m, 2);
      core_prev = slot - 1;
      bus_prev = slot - 1;
      core_on = 1;
      bus_on = 1;
      rst_n = 1'b1;
      wait_idle();
   endtask

   task automatic write_reg(input logic [6:0] val, input logic [6:0] exp_rd, input string req);
      @(posedge clk); #1;
      wr_en = 1'b1;
      wr_data = val;
      @(posedge clk); #1;
      wr_en = 1'b0;
      check(rd_data == exp_rd, req, rd_data, exp_rd);
   endtask

   task automatic measure(input int core_n, input int bus_p);
      push_core(core_n, 3);
      push_bus(bus_p, 2);
      core_prev = -1; bus_prev = -1;
      core_on = 1; bus_on = 1;
      wait_idle();
   endtask

   initial begin
      // R2 R3 R8 R9: each boot option from a fresh reset
      boot(2'b00, 8, 2, 7'h17);
      boot(2'b01, 4, 2, 7'h13);
      boot(2'b10, 2, 2, 7'h11);
      boot(2'b11, 1, 2, 7'h10);

      // R5: option changes after reset are ignored
      boot_opt = 2'b00;
      repeat (10) @(posedge clk);
      #1;
      check(rd_data == 7'h10, "R5 option ignored after reset", rd_data, 7'h10);
      measure(1, 2);

      // R6 R9 R1: core 0, bus 4 gives divide-by-5 on the bus enable
      write_reg(7'h40, 7'h40, "R6 readback after write");
      repeat (20) @(posedge clk);
      measure(1, 5);

      // R1: core 7, bus 0
      write_reg(7'h07, 7'h07, "R6 readback core 7");
      repeat (40) @(posedge clk);
      measure(8, 8);

      // R10: write in the cycle after a core pulse; the running period stays 8
      do begin
         @(posedge clk); #1;
      end while (!core_ce);
      push_core(8, 1);
      push_core(3, 2);
      core_prev = -1;
      core_on = 1;
      wr_en = 1'b1;
      wr_data = 7'h12;
      @(posedge clk); #1;
      wr_en = 1'b0;
      check(rd_data == 7'h12, "R6 readback mid-period", rd_data, 7'h12);
      wait_idle();
      repeat (20) @(posedge clk);
      measure(3, 6);

      // R7: writes refused while low-power run holds
      @(posedge clk); #1;
      lp_run = 1'b1;
      write_reg(7'h7F, 7'h12, "R7 write blocked");
      repeat (20) @(posedge clk);
      #1;
      check(rd_data == 7'h12, "R7 fields unchanged", rd_data, 7'h12);
      measure(3, 6);
      lp_run = 1'b0;

      // R4: reset overrides earlier writes
      boot(2'b10, 2, 2, 7'h11);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule